// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches a received serial bit stream, one bit per enabled clock cycle, and decides whether the far end is sending an alarm indication signal: a stream of ones with, at most, a few stray zeros. The stream is cut into back-to-back, non-overlapping blocks of 2048 enabled bits. The block counts the zeros in each one. When a block ends, the alarm status is set if that block held fewer than three zeros and cleared if it held three or more.

Every change of the alarm status, in either direction, sets a sticky transition flag. The flag stays set until the host clears it. An interrupt request follows the flag unless it is masked. The bit enable lets the block sit behind a recovered clock that does not toggle on every system clock cycle.

Top module: `ais_detector`

## Requirements
- R1: After reset `ais_o`, `trans_flag_o` and `irq_o` are 0, and the bit and zero counters start from zero.
- R2: When a block of 2048 enabled bits contains fewer than three zeros (`rx_bit` = 0), `ais_o` is 1 from the clock edge that takes the block's last bit.
- R3: When a block of 2048 enabled bits contains three or more zeros, `ais_o` is 0 from the clock edge that takes the block's last bit. Zeros at any position count, the first and last bit included.
- R4: `ais_o` changes only at the edge that ends a block, and stays stable in the middle of a block.
- R5: Cycles with `bit_en` = 0 are ignored: they neither advance the block nor count as zeros, whatever `rx_bit` holds.
- R6: `trans_flag_o` is set at the same edge where `ais_o` changes, from 0 to 1 or from 1 to 0. A block that ends without a status change does not set it.
- R7: `trans_flag_o` stays set until `flag_clr` is 1 at a clock edge. If a status change happens at that same edge, the flag stays set.
- R8: `irq_o` is 1 exactly when `trans_flag_o` is 1 and `irq_mask` is 0.
- R9: Blocks follow one another without overlap, and the zero count restarts at each block boundary. Zeros from one block never count toward the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a cycle that carries one received bit |
| rx_bit | input | 1 | Received data bit, sampled when `bit_en` is 1 |
| flag_clr | input | 1 | Host clear for the transition flag |
| irq_mask | input | 1 | 1 blocks the interrupt request |
| ais_o | output | 1 | Alarm indication status |
| trans_flag_o | output | 1 | Sticky flag for a change of the status |
| irq_o | output | 1 | Interrupt request |

## Verification
The blocks under test carry zero counts of 0, 1, 2, 3, 5 and 2048. These show where the boundary between two and three zeros lies. The zeros are placed at the front of a block, at its end (so the last bit counts) and spread across it. Pairs of consecutive two-zero blocks show whether a count carries over a block boundary. Blocks with idle cycles that carry zeros show whether disabled cycles are ignored. A mid-block probe of the status separates evaluation at block end from evaluation bit by bit. Masked, held and colliding clear cases separate the interrupt path from the flag and show which wins when a clear meets a transition.

// File: rtl/ais_pkg.sv
package ais_pkg;

    // Registered status of the detector
    typedef struct packed {
        logic ais;
        logic flag;
    } ais_stat_t;

endpackage

// File: rtl/ais_block_ctr.sv
module ais_block_ctr #(
    parameter int BLOCK_BITS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic blk_end
);
    localparam int CW = $clog2(BLOCK_BITS);
    localparam logic [CW-1:0] LAST = CW'(BLOCK_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d   = ctr_q;
        blk_end = bit_en && (ctr_q.cnt == LAST);
        if (bit_en) begin
            if (ctr_q.cnt == LAST) begin
                ctr_d.cnt = '0;
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end
endmodule

// File: rtl/ais_zero_tally.sv
module ais_zero_tally #(
    parameter int ZERO_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic blk_end,
    output logic below_limit
);
    localparam int ZW = $clog2(ZERO_LIMIT + 1);
    localparam logic [ZW-1:0] SAT = ZW'(ZERO_LIMIT);

    typedef struct packed {
        logic [ZW-1:0] zeros;
    } tally_t;

    tally_t tally_d, tally_q;
    logic [ZW-1:0] with_cur;

    always_comb begin
        tally_d  = tally_q;
        with_cur = tally_q.zeros;
        // Count the zero on this bit, but never past the limit
        if (bit_en && !rx_bit && (tally_q.zeros != SAT)) begin
            with_cur = tally_q.zeros + 1'b1;
        end
        below_limit = (with_cur < SAT);
        if (blk_end) begin
            tally_d.zeros = '0;
        end else begin
            tally_d.zeros = with_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end
endmodule

// File: rtl/ais_status.sv
module ais_status
    import ais_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_end,
    input  logic below_limit,
    input  logic flag_clr,
    input  logic irq_mask,
    output logic ais_o,
    output logic trans_flag_o,
    output logic irq_o
);
    ais_stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (blk_end) begin
            st_d.ais = below_limit;
        end
        // A new transition takes priority over the host clear
        if (st_d.ais != st_q.ais) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ais_o        = st_q.ais;
    assign trans_flag_o = st_q.flag;
    assign irq_o        = st_q.flag & ~irq_mask;
endmodule

// File: rtl/ais_detector.sv
module ais_detector #(
    parameter int BLOCK_BITS = 2048,
    parameter int ZERO_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic flag_clr,
    input  logic irq_mask,
    output logic ais_o,
    output logic trans_flag_o,
    output logic irq_o
);
    logic blk_end;
    logic below_limit;

    ais_block_ctr #(.BLOCK_BITS(BLOCK_BITS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .blk_end (blk_end)
    );

    ais_zero_tally #(.ZERO_LIMIT(ZERO_LIMIT)) u_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .rx_bit      (rx_bit),
        .blk_end     (blk_end),
        .below_limit (below_limit)
    );

    ais_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_end      (blk_end),
        .below_limit  (below_limit),
        .flag_clr     (flag_clr),
        .irq_mask     (irq_mask),
        .ais_o        (ais_o),
        .trans_flag_o (trans_flag_o),
        .irq_o        (irq_o)
    );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic flag_clr,
    input logic irq_mask,
    input logic blk_end,
    input logic ais_o,
    input logic trans_flag_o,
    input logic irq_o
);
    // R4
    end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_o != $past(ais_o)) |-> $past(blk_end));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ais_o));

    // R6
    change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_o != $past(ais_o)) |-> trans_flag_o);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_flag_o && !flag_clr) |=> trans_flag_o);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> trans_flag_o);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_o);
endmodule

bind ais_detector ais_detector_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .flag_clr     (flag_clr),
    .irq_mask     (irq_mask),
    .blk_end      (blk_end),
    .ais_o        (ais_o),
    .trans_flag_o (trans_flag_o),
    .irq_o        (irq_o)
);

// File: tb/ais_detector_bench.sv
module ais_detector_bench;
    localparam int BLK = 2048;
    localparam int NVEC = 10;
    // {zero count, placement (0 front, 1 end, 2 spread), expected ais, expected flag}
    localparam logic [15:0] VEC [NVEC] = '{
        {12'd0,    2'd0, 1'b1, 1'b1},
        {12'd2,    2'd1, 1'b1, 1'b0},
        {12'd3,    2'd2, 1'b0, 1'b1},
        {12'd5,    2'd0, 1'b0, 1'b0},
        {12'd1,    2'd1, 1'b1, 1'b1},
        {12'd2048, 2'd0, 1'b0, 1'b1},
        {12'd2,    2'd0, 1'b1, 1'b1},
        {12'd3,    2'd1, 1'b0, 1'b1},
        {12'd2,    2'd1, 1'b1, 1'b1},
        {12'd2,    2'd2, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rx_bit = 1'b1;
    logic flag_clr = 1'b0;
    logic irq_mask = 1'b0;
    logic ais_o, trans_flag_o, irq_o;
    int n_chk = 0;
    int n_fail = 0;
    logic cur_ais = 1'b0;

    always #5 clk = ~clk;

    ais_detector u_ais_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .flag_clr     (flag_clr),
        .irq_mask     (irq_mask),
        .ais_o        (ais_o),
        .trans_flag_o (trans_flag_o),
        .irq_o        (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_zero(input int i, input int z, input int mode);
        case (mode)
            0: return i < z;
            1: return i >= BLK - z;
            default: return (i % 512 == 0) && (i / 512 < z);
        endcase
    endfunction

    // Send one block; probe status mid-block; optional idle gaps and clear on last bit
    task automatic send_block(input int z, input int mode, input bit gaps, input bit clr_last);
        for (int i = 0; i < BLK; i++) begin
            @(negedge clk);
            if (i == BLK / 2) check("R4 mid-block status", int'(ais_o), int'(cur_ais));
            bit_en = 1'b1;
            rx_bit = !is_zero(i, z, mode);
            flag_clr = clr_last && (i == BLK - 1);
            if (gaps) begin
                @(negedge clk);
                bit_en = 1'b0;
                rx_bit = 1'b0;
            end
        end
        @(negedge clk);
        bit_en = 1'b0;
        rx_bit = 1'b1;
        flag_clr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R7 flag cleared by host", int'(trans_flag_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ais after reset", int'(ais_o), 0);
        check("R1 flag after reset", int'(trans_flag_o), 0);
        check("R1 irq after reset", int'(irq_o), 0);
        rst_n = 1'b1;

        // R2 R3 R6 R9 vector walk
        for (int v = 0; v < NVEC; v++) begin
            send_block(int'(VEC[v][15:4]), int'(VEC[v][3:2]), 1'b0, 1'b0);
            check(VEC[v][1] ? "R2 ais set" : "R3 ais clear", int'(ais_o), int'(VEC[v][1]));
            check("R6 transition flag", int'(trans_flag_o), int'(VEC[v][0]));
            check("R8 irq follows flag", int'(irq_o), int'(VEC[v][0]));
            cur_ais = VEC[v][1];
            clear_flag();
        end

        // R5 idle cycles carry zeros that must be ignored
        send_block(0, 0, 1'b1, 1'b0);
        check("R5 idle zeros ignored ais", int'(ais_o), 1);
        check("R5 idle zeros ignored flag", int'(trans_flag_o), 0);

        // R8 masked transition
        irq_mask = 1'b1;
        send_block(4, 2, 1'b0, 1'b0);
        cur_ais = 1'b0;
        check("R3 ais clear masked run", int'(ais_o), 0);
        check("R6 flag under mask", int'(trans_flag_o), 1);
        check("R8 irq masked", int'(irq_o), 0);
        irq_mask = 1'b0;
        @(negedge clk);
        check("R8 irq after unmask", int'(irq_o), 1);
        repeat (20) @(negedge clk);
        check("R7 flag held without clear", int'(trans_flag_o), 1);
        clear_flag();

        // R7 clear on the same edge as a transition
        send_block(0, 0, 1'b0, 1'b1);
        cur_ais = 1'b1;
        check("R2 ais set collision run", int'(ais_o), 1);
        check("R7 transition beats clear", int'(trans_flag_o), 1);
        clear_flag();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule